// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of several identical shallow slices. Each slice has its own storage, write and read pointers, and a fill count. Write and read ownership pass from slice to slice as tokens, so no slice needs a wide address. All slices share the write strobe, the read strobe and the reset.

After reset, the slice whose lead input is low holds both tokens. A slice that stores into its last location raises a one-cycle write hand-off pulse, and that pulse gives write ownership to the next slice in the ring. Reads pass their token in the same way. The last slice feeds the first, so the ring is closed. A slice that receives a pulse may use the token in the same cycle the pulse is present, and it keeps the token from the following clock edge onwards. Because of this, strobes issued back to back lose nothing at a slice boundary.

The wrapper combines the per-slice flags. The buffer reports full only when every slice is full, and empty only when every slice is empty. Read data is taken from whichever slice performed the read, and every other slice holds its data output at zero. Retransmit and half-full indication are not offered.

Top module: `depth_chain_fifo`

## Requirements
- R1: After reset, `emptyAll` is 1, `fullAll` is 0 and `rdValid` is 0.
- R2: Words leave the buffer in the order they were accepted, across slice boundaries and across many trips of both tokens around the ring.
- R3: A write strobe while `fullAll` is 1 stores nothing, and the held contents stay unchanged.
- R4: A read strobe while `emptyAll` is 1 is ignored: `rdValid` stays 0 in the next cycle.
- R5: An accepted read at a clock edge shows its word on `rdData` with `rdValid` at 1 during the following cycle. `rdData` is all zeros whenever `rdValid` is 0.
- R6: `fullAll` is 1 exactly when `SLICES*DEPTH` words are held.
- R7: `emptyAll` is 1 exactly when no word is held.
- R8: A write into a slice's last location makes that slice raise a single-cycle write hand-off pulse. The next slice accepts a write in the very next cycle, so a continuous write burst loses no strobe.
- R9: A read from a slice's last location hands the read token on in the same way, so a continuous read burst loses no strobe.
- R10: A read and a write in the same cycle are both accepted unless a flag blocks one of them. At full, only the read is taken. At empty, only the write is taken.
- R11: At most one slice drives read data in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrStb | input | 1 | Write request for this cycle |
| wrData | input | WIDTH | Word to store |
| rdStb | input | 1 | Read request for this cycle |
| rdData | output | WIDTH | Word read in the previous cycle, zero otherwise |
| rdValid | output | 1 | High in the cycle after an accepted read |
| fullAll | output | 1 | Every slice is full |
| emptyAll | output | 1 | Every slice is empty |

## Verification
Suppose a token is lost, duplicated or taken late. The first burst that crosses a slice boundary then shows it at the ports: a strobe goes missing, or a word repeats or comes out of order, and this is visible in `rdData` within one cycle of the read that reaches the affected location. Suppose instead that a slice's count or pointers drift. The combined flags then disagree with the number of words accepted, either in the same cycle or at the latest when the buffer next fills or drains. The stimulus therefore runs full-depth bursts both ways, hits both flags with extra strobes, and sends the tokens round the ring many times under random traffic.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // strobes from a slice controller to its storage
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } sliceStb_t;
endpackage

// File: rtl/fifo_slice_ctrl.sv
module fifo_slice_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          leadN,
  input  logic          wrStb,
  input  logic          rdStb,
  input  logic          wrXi,
  input  logic          rdXi,
  output sliceStb_t     stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrXo,
  output logic          rdXo,
  output logic          emptyF,
  output logic          fullF
);
  logic wrTok, rdTok, wrOwn, rdOwn, wrLast, rdLast;
  logic [CW-1:0] fillCnt;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // a token counts as held while its hand-off pulse is arriving
  assign wrOwn  = wrTok | wrXi;
  assign rdOwn  = rdTok | rdXi;
  assign emptyF = (fillCnt == '0);
  assign fullF  = (fillCnt == CW'(DEPTH));
  assign stb.wrEn = wrStb & wrOwn & ~fullF;
  assign stb.rdEn = rdStb & rdOwn & ~emptyF;
  assign wrLast = stb.wrEn && (wrAddr == LAST);
  assign rdLast = stb.rdEn && (rdAddr == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrTok   <= ~leadN;
      rdTok   <= ~leadN;
      wrAddr  <= '0;
      rdAddr  <= '0;
      fillCnt <= '0;
      wrXo    <= 1'b0;
      rdXo    <= 1'b0;
    end else begin
      wrTok <= wrOwn & ~wrLast;
      rdTok <= rdOwn & ~rdLast;
      wrXo  <= wrLast;
      rdXo  <= rdLast;
      if (stb.wrEn) wrAddr <= wrLast ? '0 : wrAddr + 1'b1;
      if (stb.rdEn) rdAddr <= rdLast ? '0 : rdAddr + 1'b1;
      case ({stb.wrEn, stb.rdEn})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CW'(DEPTH));
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullF && !rdStb) |=> fullF);
  // R8
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrXo |=> !wrXo);
  // R8
  wr_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrXi |=> wrTok);
  // R9
  rd_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdXi |=> rdTok);
endmodule

// File: rtl/fifo_slice_data.sv
module fifo_slice_data
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sliceStb_t        stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] dOut,
  output logic             dOutEn
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (stb.wrEn) store[wrAddr] <= wrData;
    if (stb.rdEn) dataQ <= store[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) dOutEn <= 1'b0;
    else       dOutEn <= stb.rdEn;
  end

  // an idle slice contributes zeros to the shared read bus
  assign dOut = dOutEn ? dataQ : '0;
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             leadN,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStb,
  input  logic             wrXi,
  input  logic             rdXi,
  output logic             wrXo,
  output logic             rdXo,
  output logic [WIDTH-1:0] dOut,
  output logic             dOutEn,
  output logic             emptyF,
  output logic             fullF
);
  sliceStb_t stb;
  logic [AW-1:0] wrAddr, rdAddr;

  fifo_slice_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .leadN(leadN), .wrStb(wrStb), .rdStb(rdStb),
    .wrXi(wrXi), .rdXi(rdXi), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrXo(wrXo), .rdXo(rdXo), .emptyF(emptyF), .fullF(fullF)
  );

  fifo_slice_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: rtl/depth_chain_fifo.sv
module depth_chain_fifo #(
  parameter int SLICES = 3,
  parameter int DEPTH  = 4,
  parameter int WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             fullAll,
  output logic             emptyAll
);
  logic [SLICES-1:0] wrXoV, rdXoV, wrXiV, rdXiV, outEnV, fullV, emptyV;
  logic [WIDTH-1:0]  dOutV [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : gSlice
    localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
    assign wrXiV[i] = wrXoV[PREV];
    assign rdXiV[i] = rdXoV[PREV];
    fifo_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uSlice (
      .clk(clk), .rstN(rstN), .leadN(i != 0), .wrStb(wrStb), .wrData(wrData),
      .rdStb(rdStb), .wrXi(wrXiV[i]), .rdXi(rdXiV[i]), .wrXo(wrXoV[i]),
      .rdXo(rdXoV[i]), .dOut(dOutV[i]), .dOutEn(outEnV[i]),
      .emptyF(emptyV[i]), .fullF(fullV[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < SLICES; i++) rdData |= dOutV[i];
  end

  assign rdValid  = |outEnV;
  assign fullAll  = &fullV;
  assign emptyAll = &emptyV;

  // R11
  one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outEnV));
  // R8
  wr_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrXoV));
  // R9
  rd_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdXoV));
endmodule

// File: tb/sim_depth_chain_fifo.sv
`timescale 1ns/1ps
module sim_depth_chain_fifo;
  localparam int SLICES = 3;
  localparam int DEPTH  = 4;
  localparam int WIDTH  = 9;
  localparam int CAP    = SLICES * DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0, rdStb = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic rdValid, fullAll, emptyAll;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] model[$];

  always #2.5 clk = ~clk;

  depth_chain_fifo #(.SLICES(SLICES), .DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .rdData(rdData), .rdValid(rdValid), .fullAll(fullAll), .emptyAll(emptyAll)
  );

  function automatic void check(input bit ok, input string tag,
                                input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // one cycle: drive at negedge, sample at the following negedge
  task automatic step(input bit w, input logic [WIDTH-1:0] d, input bit r,
                      input string tag);
    bit wAcc, rAcc;
    logic [WIDTH-1:0] expD;
    wAcc = w && (model.size() < CAP);
    rAcc = r && (model.size() > 0);
    expD = '0;
    if (rAcc) expD = model.pop_front();
    if (wAcc) model.push_back(d);
    wrStb = w; wrData = d; rdStb = r;
    @(posedge clk);
    @(negedge clk);
    check(rdValid == rAcc, {tag, " valid"}, rdValid, rAcc);
    check(rdData == expD, {tag, " R5 data"}, rdData, expD);
    check(fullAll == (model.size() == CAP), "R6 full", fullAll, model.size() == CAP);
    check(emptyAll == (model.size() == 0), "R7 empty", emptyAll, model.size() == 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(emptyAll == 1'b1, "R1 empty", emptyAll, 1);
    check(fullAll == 1'b0, "R1 full", fullAll, 0);
    check(rdValid == 1'b0, "R1 valid", rdValid, 0);
    // R8 fill with a continuous burst across every boundary
    for (int i = 0; i < CAP; i++) step(1, WIDTH'(i + 16), 0, "R8");
    // R3 writes while full are dropped
    for (int i = 0; i < 3; i++) step(1, WIDTH'(9'h1AA), 0, "R3");
    // R10 read and write together at full: only the read
    step(1, WIDTH'(9'h155), 1, "R10");
    // R9 continuous drain, R2 order
    for (int i = 0; i < CAP + 1; i++) step(0, '0, 1, "R9 R2");
    // R4 reads while empty
    for (int i = 0; i < 3; i++) step(0, '0, 1, "R4");
    // R10 read and write together at empty: only the write
    step(1, WIDTH'(9'h0C3), 1, "R10");
    step(0, '0, 1, "R10");
    // R2 random traffic with drifting bias
    for (int i = 0; i < 4000; i++) begin
      int bias;
      bias = ((i / 200) % 2 == 0) ? 70 : 30;
      step(($urandom % 100) < bias, WIDTH'($urandom), ($urandom % 100) < (100 - bias), "R2");
    end
    for (int i = 0; i < CAP + 1; i++) step(0, '0, 1, "R2 drain");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule